// File: doc/BRIEF.md
# Serial Transmit Engine with Character Queue

This block turns characters written by a host into asynchronous serial frames on a single output line. Characters enter through a valid/ready write port and wait in a 16-entry queue. A shifter pulls one character at a time and sends it as a frame: a start bit, the data bits, an optional parity bit, and a stop interval. Every bit time is counted on an external strobe that pulses at sixteen times the bit rate.

The frame layout is chosen by a 3-bit mode code, a parity-sense pin and a 2-bit stop code. The stop interval can be half a bit, one bit, one and a half bits or two bits. When flow control is enabled, a deasserted clear-to-send input keeps the next frame from starting. A clear strobe drops everything still queued. Four status pins report the fill level. A loopback pin sends the serial stream to the receive-side output and holds the external line idle.

Back-pressure on the write port works as follows. A character is accepted on a rising clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low exactly when the queue holds 16 characters. A character offered while `wr_ready` is low is dropped, not held. The host must keep `wr_valid` high until it sees `wr_ready`.

Top module: `sertx_top`

## Requirements
- R1: The queue holds 16 characters of 9 bits. A write is accepted when `wr_valid && wr_ready`. `wr_ready` is low when 16 characters are stored, and a character offered while full is discarded and never sent.
- R2: The line idles high. A frame starts with a low start bit of 16 ticks, then sends the payload bits least-significant first, 16 ticks each.
- R3: Mode codes set the payload. 001 sends data[7:0]. 011 sends data[6:0] then parity. 100 sends data[8:0]. 101 sends data[7:0] then data[8] as the wake-up bit. 111 sends data[7:0] then parity. Any other code behaves like 001.
- R4: With `parity_odd` = 0, the parity bit makes the number of ones across the data bits and parity even. With `parity_odd` = 1, it makes that count odd.
- R5: After the last payload bit, the line is high for a stop interval set by `stop_sel`: 00 gives 8 ticks, 01 gives 16, 10 gives 24 and 11 gives 32.
- R6: `st_empty` is high only when the queue is empty and the shifter has finished the stop interval of its last frame.
- R7: `st_nonempty` is high when at least one character is queued. `st_half` is high when 8 or fewer are queued. `st_full` is high when 16 are queued.
- R8: While `cts_enable` is 1 and `cts` is 0, no new frame starts and queued characters stay queued.
- R9: A `fifo_clear` pulse empties the queue on the next edge, and it overrides a write in the same cycle.
- R10: With `loopback` = 1, `txd` is held high and `rx_out` carries the serial stream. With `loopback` = 0, `txd` carries the stream and `rx_out` follows `rxd_in`.
- R11: Frame timing advances only on cycles where `tick16` is high. Without ticks, the line holds its level.
- R12: After reset, `txd` is high, the queue is empty, `st_empty`, `st_half` and `wr_ready` are high, and `st_nonempty` and `st_full` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle strobe at 16x the bit rate |
| wr_valid | input | 1 | Host offers a character |
| wr_ready | output | 1 | Queue can accept a character |
| wr_data | input | 9 | Character to send |
| fifo_clear | input | 1 | Empty the queue |
| mode | input | 3 | Frame mode code |
| stop_sel | input | 2 | Stop interval code |
| parity_odd | input | 1 | 1 selects odd parity |
| loopback | input | 1 | Route the stream internally |
| cts_enable | input | 1 | Obey the clear-to-send input |
| cts | input | 1 | Clear to send, high means permitted |
| rxd_in | input | 1 | External receive line |
| txd | output | 1 | Serial output line |
| rx_out | output | 1 | Line presented to a receiver |
| st_empty | output | 1 | Queue empty and shifter idle |
| st_half | output | 1 | 8 or fewer queued |
| st_nonempty | output | 1 | At least one queued |
| st_full | output | 1 | 16 queued |

## Verification
The bench measures each frame from its start edge to the rise of `st_empty`. A shifter that miscounts a fractional stop interval, or raises empty before the stop ends, therefore shows a length error. It decodes both parity senses on 7-bit and 8-bit payloads, covers the 9-bit and wake-up modes, and uses an unlisted mode code, so a swapped parity sense or a dropped ninth bit shows up as a wrong bit.

With clear-to-send held off, the bench fills the queue and checks the half-level boundary between 8 and 9 entries. It then offers a seventeenth character. A queue that overwrote an entry would send a wrong character, and one that accepted the extra character would send a seventeenth frame. A clear pulse that collides with a write, a stalled tick in mid-frame, and the loopback routing are each checked at the pins.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int CHAR_W    = 9;
  localparam int TICKS_BIT = 16;
  localparam int TICKS_HALF = TICKS_BIT / 2;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_START = 2'd1,
    TX_BITS  = 2'd2,
    TX_STOP  = 2'd3
  } tx_state_e;

  localparam logic [2:0] MODE_D8    = 3'b001;
  localparam logic [2:0] MODE_D7P   = 3'b011;
  localparam logic [2:0] MODE_D9    = 3'b100;
  localparam logic [2:0] MODE_D8W   = 3'b101;
  localparam logic [2:0] MODE_D8P   = 3'b111;
endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16   // power of two
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full,
  output logic             half
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [AW:0]      cnt;
  logic             do_push, do_pop;

  assign do_push = push && !full && !clear;
  assign do_pop  = pop && !empty && !clear;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clear) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == (AW+1)'(DEPTH));
  assign half  = (cnt <= (AW+1)'(DEPTH / 2));

  // R1
  full_no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clear) |=> (full && $stable(wp)));

  // R9
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> empty);

  // R7
  half_full_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !half);
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [2:0]        mode,
  input  logic [1:0]        stop_sel,
  input  logic              parity_odd,
  input  logic              cts_en,
  input  logic              cts,
  input  logic              have_data,
  input  logic [CHAR_W-1:0] data,
  output logic              pop,
  output logic              busy,
  output logic              line
);
  localparam int CW = $clog2(4 * TICKS_HALF);
  localparam logic [CW-1:0] BIT_LAST = CW'(TICKS_BIT - 1);

  tx_state_e      state;
  logic [CW-1:0]  tcnt;
  logic [CW-1:0]  stop_last;
  logic [3:0]     idx, nb_last;
  logic [9:0]     shreg;
  logic [9:0]     payload;
  logic [3:0]     payload_last;
  logic           par7, par8;

  assign par7 = (^data[6:0]) ^ parity_odd;
  assign par8 = (^data[7:0]) ^ parity_odd;

  always_comb begin
    case (mode)
      MODE_D7P: begin payload = {2'b00, par7, data[6:0]}; payload_last = 4'd7; end
      MODE_D9,
      MODE_D8W: begin payload = {1'b0, data[8:0]};        payload_last = 4'd8; end
      MODE_D8P: begin payload = {1'b0, par8, data[7:0]};  payload_last = 4'd8; end
      default:  begin payload = {2'b00, data[7:0]};       payload_last = 4'd7; end
    endcase
  end

  assign pop  = (state == TX_IDLE) && have_data && (!cts_en || cts);
  assign busy = (state != TX_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= TX_IDLE;
      tcnt      <= '0;
      idx       <= '0;
      nb_last   <= '0;
      shreg     <= '0;
      stop_last <= '0;
    end else begin
      case (state)
        TX_IDLE: if (pop) begin
          state     <= TX_START;
          tcnt      <= '0;
          shreg     <= payload;
          nb_last   <= payload_last;
          stop_last <= CW'((int'(stop_sel) + 1) * TICKS_HALF - 1);
        end
        TX_START: if (tick) begin
          if (tcnt == BIT_LAST) begin
            state <= TX_BITS;
            tcnt  <= '0;
            idx   <= '0;
          end else tcnt <= tcnt + 1'b1;
        end
        TX_BITS: if (tick) begin
          if (tcnt == BIT_LAST) begin
            tcnt  <= '0;
            shreg <= shreg >> 1;
            idx   <= idx + 1'b1;
            if (idx == nb_last) state <= TX_STOP;
          end else tcnt <= tcnt + 1'b1;
        end
        TX_STOP: if (tick) begin
          if (tcnt == stop_last) state <= TX_IDLE;
          else tcnt <= tcnt + 1'b1;
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      TX_START: line = 1'b0;
      TX_BITS:  line = shreg[0];
      default:  line = 1'b1;
    endcase
  end

  // R8
  cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_en && !cts && state == TX_IDLE) |=> (state == TX_IDLE));

  // R11
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && state != TX_IDLE) |=> $stable(line));
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic              fifo_clear,
  input  logic [2:0]        mode,
  input  logic [1:0]        stop_sel,
  input  logic              parity_odd,
  input  logic              loopback,
  input  logic              cts_enable,
  input  logic              cts,
  input  logic              rxd_in,
  output logic              txd,
  output logic              rx_out,
  output logic              st_empty,
  output logic              st_half,
  output logic              st_nonempty,
  output logic              st_full
);
  logic [CHAR_W-1:0] q_data;
  logic              q_empty, q_full, q_half;
  logic              pop, busy, serial;

  sertx_fifo #(.WIDTH(CHAR_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (fifo_clear),
    .push  (wr_valid),
    .din   (wr_data),
    .pop   (pop),
    .dout  (q_data),
    .empty (q_empty),
    .full  (q_full),
    .half  (q_half)
  );

  sertx_shifter u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick16),
    .mode       (mode),
    .stop_sel   (stop_sel),
    .parity_odd (parity_odd),
    .cts_en     (cts_enable),
    .cts        (cts),
    .have_data  (!q_empty),
    .data       (q_data),
    .pop        (pop),
    .busy       (busy),
    .line       (serial)
  );

  assign wr_ready    = !q_full;
  assign st_full     = q_full;
  assign st_half     = q_half;
  assign st_nonempty = !q_empty;
  assign st_empty    = q_empty && !busy;
  assign txd         = loopback ? 1'b1 : serial;
  assign rx_out      = loopback ? serial : rxd_in;

  // R6
  empty_line_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_empty |-> (serial && !st_nonempty));

  // R10
  loop_holds_txd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loopback |-> txd);
endmodule

// File: tb/tb_sertx_top.sv
module tb_sertx_top;
  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b1;
  logic wr_valid = 1'b0, fifo_clear = 1'b0;
  logic [8:0] wr_data = '0;
  logic [2:0] mode = 3'b001;
  logic [1:0] stop_sel = 2'b01;
  logic parity_odd = 1'b0, loopback = 1'b0, cts_enable = 1'b0, cts = 1'b1, rxd_in = 1'b1;
  logic wr_ready, txd, rx_out, st_empty, st_half, st_nonempty, st_full;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sertx_top dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .fifo_clear(fifo_clear), .mode(mode), .stop_sel(stop_sel),
    .parity_odd(parity_odd), .loopback(loopback), .cts_enable(cts_enable), .cts(cts),
    .rxd_in(rxd_in), .txd(txd), .rx_out(rx_out), .st_empty(st_empty), .st_half(st_half),
    .st_nonempty(st_nonempty), .st_full(st_full));

  // fields: [14:12] mode, [11:10] stop code, [9] odd parity, [8:0] data
  localparam logic [14:0] VEC [8] = '{
    {3'b001, 2'b01, 1'b0, 9'h0A5},
    {3'b011, 2'b01, 1'b0, 9'h035},
    {3'b011, 2'b01, 1'b1, 9'h035},
    {3'b111, 2'b11, 1'b0, 9'h0F1},
    {3'b111, 2'b00, 1'b1, 9'h081},
    {3'b100, 2'b10, 1'b0, 9'h1C3},
    {3'b101, 2'b01, 1'b0, 9'h155},
    {3'b000, 2'b01, 1'b0, 9'h1FF}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_nb(input logic [2:0] m);
    case (m)
      3'b100, 3'b101, 3'b111: return 9;
      default: return 8;
    endcase
  endfunction

  function automatic logic [9:0] exp_bits(input logic [2:0] m, input logic odd, input logic [8:0] d);
    case (m)
      3'b011: return {2'b00, (^d[6:0]) ^ odd, d[6:0]};
      3'b111: return {1'b0, (^d[7:0]) ^ odd, d[7:0]};
      3'b100, 3'b101: return {1'b0, d};
      default: return {2'b00, d[7:0]};
    endcase
  endfunction

  task automatic push(input logic [8:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_low();
    do @(negedge clk); while (txd !== 1'b0);
  endtask

  // decode one frame after its start edge; ends inside the stop interval
  task automatic rx_frame(input int nb, output logic [9:0] bits);
    bits = '0;
    wait_low();
    repeat (8) @(negedge clk);
    for (int k = 0; k < nb; k++) begin
      repeat (16) @(negedge clk);
      bits[k] = txd;
    end
    repeat (9) @(negedge clk);
  endtask

  initial begin
    #(64'd200000 * 20);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [9:0] got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(txd && st_empty && st_half && wr_ready && !st_nonempty && !st_full, "R12",
        {txd, st_empty, st_half, wr_ready, st_nonempty, st_full}, 6'b111100);

    // table: R2 R3 R4 R5 bit contents and frame length
    foreach (VEC[i]) begin
      int nb, sticks, t, len;
      logic [9:0] expb, bits;
      logic startok, stopok;
      mode = VEC[i][14:12]; stop_sel = VEC[i][11:10]; parity_odd = VEC[i][9];
      nb = exp_nb(mode);
      expb = exp_bits(mode, parity_odd, VEC[i][8:0]);
      sticks = (int'(stop_sel) + 1) * 8;
      push(VEC[i][8:0]);
      wait_low();
      t = 0; bits = '0; startok = 1'b0; stopok = 1'b1;
      while (st_empty !== 1'b1 && t < 1000) begin
        @(negedge clk); t++;
        if (t == 8) startok = (txd == 1'b0);
        for (int k = 0; k < nb; k++) if (t == 16 * (k + 1) + 8) bits[k] = txd;
        if (t > 16 * (nb + 1) && txd !== 1'b1) stopok = 1'b0;
      end
      len = t;
      chk(startok && stopok && bits == expb, "R2/R3/R4 frame bits", bits, expb);
      chk(len == (1 + nb) * 16 + sticks, "R5/R6 frame length", len, (1 + nb) * 16 + sticks);
    end

    // R8 hold with CTS, R7 levels, R1 full and discard
    mode = 3'b001; stop_sel = 2'b01; parity_odd = 1'b0;
    cts_enable = 1'b1; cts = 1'b0;
    begin
      logic lowseen = 1'b0;
      for (int n = 0; n < 16; n++) begin
        push(9'(n * 3 + 1));
        if (txd !== 1'b1) lowseen = 1'b1;
        if (n == 7) chk(st_half && st_nonempty, "R7 half at 8", st_half, 1);
        if (n == 8) chk(!st_half, "R7 half clear at 9", st_half, 0);
      end
      chk(st_full && !wr_ready && !st_empty, "R1/R7 full", {st_full, wr_ready}, 2'b10);
      push(9'h0EE);
      repeat (30) @(negedge clk);
      chk(!lowseen && txd, "R8 CTS holds frames", txd, 1);
    end
    cts = 1'b1;
    for (int n = 0; n < 16; n++) begin
      rx_frame(8, got);
      chk(got[7:0] == 8'(n * 3 + 1), "R1/R8 queued order", got[7:0], n * 3 + 1);
    end
    begin
      logic lowseen = 1'b0;
      repeat (200) begin
        @(negedge clk);
        if (txd !== 1'b1) lowseen = 1'b1;
      end
      chk(!lowseen && st_empty, "R1 discarded write not sent", lowseen, 0);
    end

    // R9 clear overrides a simultaneous write
    cts = 1'b0;
    for (int n = 0; n < 5; n++) push(9'h011);
    @(negedge clk);
    fifo_clear = 1'b1; wr_valid = 1'b1; wr_data = 9'h022;
    @(negedge clk);
    fifo_clear = 1'b0; wr_valid = 1'b0;
    chk(!st_nonempty && st_empty && st_half, "R9 clear empties", st_nonempty, 0);
    cts = 1'b1;
    begin
      logic lowseen = 1'b0;
      repeat (60) begin
        @(negedge clk);
        if (txd !== 1'b1) lowseen = 1'b1;
      end
      chk(!lowseen, "R9 nothing sent after clear", lowseen, 0);
    end
    cts_enable = 1'b0;

    // R10 loopback
    rxd_in = 1'b0;
    @(negedge clk);
    chk(rx_out == 1'b0, "R10 rx_out follows rxd_in", rx_out, 0);
    rxd_in = 1'b1; loopback = 1'b1;
    push(9'h000);
    do @(negedge clk); while (rx_out !== 1'b0);
    chk(txd == 1'b1, "R10 txd held idle in loopback", txd, 1);
    do @(negedge clk); while (st_empty !== 1'b1);
    loopback = 1'b0;

    // R11 tick stall mid start bit
    push(9'h0FF);
    wait_low();
    repeat (3) @(negedge clk);
    tick16 = 1'b0;
    repeat (60) @(negedge clk);
    chk(txd == 1'b0 && !st_empty, "R11 line holds without ticks", txd, 0);
    tick16 = 1'b1;
    begin
      int t = 3;
      while (st_empty !== 1'b1 && t < 1000) begin
        @(negedge clk); t++;
      end
      chk(t == 9 * 16 + 16, "R11 timing resumes", t, 9 * 16 + 16);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule